// File: doc/BRIEF.md
# Voice Activity Path Switch Controller

This block sits in front of an audio capture subsystem. The subsystem can run in one of two ways. One is a low-power path, where a voice-activity detector listens on a single microphone channel. The other is the full digital-microphone path, where every channel is enabled and samples are streamed to memory. Software drives the controller through one 32-bit control register and one channel-enable register.

The block keeps a sticky activity flag. The flag is set by a one-cycle pulse from the external detector. When a detection is accepted, the controller moves to the microphone path and starts forwarding samples to memory, with no software action. Software stops the forwarding when it has captured enough. To return to the low-power path, software first clears the flag and enables all channels, then requests the switch. The controller rejects a switch request made before those conditions are met and records the rejection.

The outputs are:
- the channel-enable vector,
- the microphone clock-source select,
- the path select,
- the forward enable,
- the activity flag,
- the rejection status,
- the decimation ratio selected in the register.

Top module: `vad_path_ctrl`

## Requirements
- R1: After a synchronous reset, the control register reads 0x0000_0008. The channel enables are 0, the path is the detection path (path_sel = 0), and the flag, forward enable, clock-source select and error bit are all 0.
- R2: Control register layout: bit 31 = enable, bit 30 = flag clear, bit 29 = switch request, bit 28 = data-off, bits [11:8] = decimation code. Written values of these fields read back. Bit 3 always reads 1. Every other bit reads 0 whatever is written.
- R3: ratio_o gives the decimation ratio as a 7-bit value: code 0 gives 48, code 1 gives 64, and every other code gives 64.
- R4: A write that takes the enable bit from 0 to 1 sets the channel enables to 4'b0001 at the next edge. This takes priority over a channel write in the same cycle. Otherwise a channel write loads chan_wdata.
- R5: clk_src_o equals the stored enable bit (1 = the clock comes from the detection block).
- R6: A detect pulse sets the flag only while the stored enable is 1 and the path is the detection path. Otherwise it is ignored.
- R7: A register write with bit 30 = 1 clears the flag. Writing bit 30 as 0 has no effect. If an accepted detect pulse falls in the same cycle as a clear write, the flag ends up set.
- R8: An accepted detection moves path_sel to 1 (microphone path) at the same edge that sets the flag.
- R9: An accepted detection sets fwd_o. A write with bit 28 = 1 clears it, as does an accepted switch. A detection in the same cycle as a data-off write leaves fwd_o set.
- R10: A switch write (bit 29 = 1) is accepted only when all of the following hold before that write: the path is the microphone path, the flag is 0, and all channel enables are 1. When accepted, path_sel returns to 0 and the channel enables are forced to 4'b0001.
- R11: A switch write made on the microphone path that is not accepted leaves the path unchanged and sets err_o. An accepted switch clears err_o. A switch write made on the detection path does nothing.
- R12: A write with bit 31 = 0 returns the path to detection and clears fwd_o at the next edge, whatever the other bits of that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 32 | Control register write value |
| rd_data | output | 32 | Control register readback |
| chan_wr | input | 1 | Channel-enable register write strobe |
| chan_wdata | input | 4 | Channel-enable write value |
| det_pulse | input | 1 | One-cycle pulse from the activity detector |
| chan_en_o | output | 4 | Microphone channel enables |
| clk_src_o | output | 1 | 1 = microphone clock from the detection block |
| path_sel_o | output | 1 | 0 = detection path, 1 = microphone path |
| fwd_o | output | 1 | Forward samples to memory |
| flag_o | output | 1 | Sticky activity flag |
| err_o | output | 1 | Last switch request was rejected |
| ratio_o | output | 7 | Selected decimation ratio |

## Verification
Three pairs of actions can collide in a single cycle:
- A flag clear and a fresh detection can land together. The bench forces them together on the detection path and expects the flag to stay set.
- A flag clear and a switch request can arrive in one write. The switch is judged on the flag value before that write, so it must be rejected and err_o must rise.
- A data-off write and a detection can coincide. Forwarding must stay on.

Random runs make every pair of these coincide repeatedly. A cycle-level reference model in the bench, written from the requirements, judges each cycle.

// File: rtl/vad_pkg.sv
package vad_pkg;

    localparam int REG_W     = 32;
    localparam int EN_BIT    = 31;
    localparam int CLR_BIT   = 30;
    localparam int SW_BIT    = 29;
    localparam int DOFF_BIT  = 28;
    localparam int OSR_LSB   = 8;
    localparam int OSR_W     = 4;
    localparam int MARK_BIT  = 3;
    localparam int CH_N      = 4;
    localparam int RATIO_W   = 7;
    localparam int RATIO_LO  = 48;
    localparam int RATIO_HI  = 64;

    typedef enum logic {
        PATH_DETECT = 1'b0,
        PATH_MIC    = 1'b1
    } path_e;

    // stored control fields
    typedef struct packed {
        logic             en;
        logic             clr;
        logic             sw;
        logic             doff;
        logic [OSR_W-1:0] osr;
    } ctrl_t;

    // one-cycle commands decoded from a register write
    typedef struct packed {
        logic en_rise;
        logic dis;
        logic clr;
        logic sw;
        logic doff;
    } cmd_t;

    function automatic logic [RATIO_W-1:0] osr_to_ratio(input logic [OSR_W-1:0] code);
        logic [RATIO_W-1:0] r;
        case (code)
            '0:      r = RATIO_W'(RATIO_LO);
            default: r = RATIO_W'(RATIO_HI);
        endcase
        return r;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c);
        logic [REG_W-1:0] v;
        v = '0;
        v[EN_BIT]                  = c.en;
        v[CLR_BIT]                 = c.clr;
        v[SW_BIT]                  = c.sw;
        v[DOFF_BIT]                = c.doff;
        v[OSR_LSB +: OSR_W]        = c.osr;
        v[MARK_BIT]                = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/vad_ctrl_reg.sv
module vad_ctrl_reg
    import vad_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output ctrl_t              ctrl_q,
    output cmd_t               cmd,
    output logic [REG_W-1:0]   rd_data,
    output logic [RATIO_W-1:0] ratio
);

    ctrl_t wr_fields;
    logic  unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[DOFF_BIT-1:OSR_LSB+OSR_W], wr_data[OSR_LSB-1:0]};

    always_comb begin
        wr_fields.en   = wr_data[EN_BIT];
        wr_fields.clr  = wr_data[CLR_BIT];
        wr_fields.sw   = wr_data[SW_BIT];
        wr_fields.doff = wr_data[DOFF_BIT];
        wr_fields.osr  = wr_data[OSR_LSB +: OSR_W];
    end

    always_comb begin
        cmd.en_rise = wr_en & wr_fields.en & ~ctrl_q.en;
        cmd.dis     = wr_en & ~wr_fields.en;
        cmd.clr     = wr_en & wr_fields.clr;
        cmd.sw      = wr_en & wr_fields.sw;
        cmd.doff    = wr_en & wr_fields.doff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= wr_fields;
        end
    end

    assign rd_data = pack_ctrl(ctrl_q);
    assign ratio   = osr_to_ratio(ctrl_q.osr);

    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data[EN_BIT] == $past(wr_data[EN_BIT])
               && rd_data[OSR_LSB +: OSR_W] == $past(wr_data[OSR_LSB +: OSR_W]));

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rd_data));

endmodule

// File: rtl/vad_chan_en.sv
module vad_chan_en #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_rise,
    input  logic         ret_force,
    input  logic         ch_wr,
    input  logic [N-1:0] ch_wdata,
    output logic [N-1:0] chan_q,
    output logic         all_on
);

    localparam logic [N-1:0] FORCE_PAT = N'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_q <= '0;
        end else if (en_rise || ret_force) begin
            chan_q <= FORCE_PAT;
        end else if (ch_wr) begin
            chan_q <= ch_wdata;
        end
    end

    assign all_on = &chan_q;

    a_r4_force: assert property (@(posedge clk) disable iff (rst)
        (en_rise || ret_force) |=> chan_q == FORCE_PAT);

    a_r4_load: assert property (@(posedge clk) disable iff (rst)
        (ch_wr && !en_rise && !ret_force) |=> chan_q == $past(ch_wdata));

endmodule

// File: rtl/vad_path_fsm.sv
module vad_path_fsm
    import vad_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  cmd_t  cmd,
    input  logic  det_pulse,
    input  logic  all_on,
    output path_e path_q,
    output logic  flag_q,
    output logic  fwd_q,
    output logic  err_q,
    output logic  sw_ok
);

    logic det_acc;
    logic in_mic;
    logic sw_bad;

    assign in_mic  = (path_q == PATH_MIC);
    assign det_acc = det_pulse & en & ~in_mic;
    assign sw_ok   = cmd.sw & in_mic & en & ~flag_q & all_on;
    assign sw_bad  = cmd.sw & in_mic & ~sw_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            path_q <= PATH_DETECT;
            flag_q <= 1'b0;
            fwd_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (det_acc)       flag_q <= 1'b1;
            else if (cmd.clr)  flag_q <= 1'b0;

            if (cmd.dis)       path_q <= PATH_DETECT;
            else if (det_acc)  path_q <= PATH_MIC;
            else if (sw_ok)    path_q <= PATH_DETECT;

            if (cmd.dis)                  fwd_q <= 1'b0;
            else if (det_acc)             fwd_q <= 1'b1;
            else if (cmd.doff || sw_ok)   fwd_q <= 1'b0;

            if (sw_bad)        err_q <= 1'b1;
            else if (sw_ok)    err_q <= 1'b0;
        end
    end

    a_r6_flag_source: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(det_pulse && en && path_q == PATH_DETECT));

    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        (cmd.clr && !det_acc) |=> !flag_q);

    a_r8_to_mic: assert property (@(posedge clk) disable iff (rst)
        (det_acc && !cmd.dis) |=> path_q == PATH_MIC && flag_q && fwd_q);

    a_r10_return: assert property (@(posedge clk) disable iff (rst)
        sw_ok |=> path_q == PATH_DETECT && !err_q);

    a_r11_reject: assert property (@(posedge clk) disable iff (rst)
        (sw_bad && !cmd.dis) |=> err_q && path_q == PATH_MIC);

    a_r12_disable: assert property (@(posedge clk) disable iff (rst)
        cmd.dis |=> path_q == PATH_DETECT && !fwd_q);

endmodule

// File: rtl/vad_path_ctrl.sv
module vad_path_ctrl
    import vad_pkg::*;
#(
    parameter int N_CH = vad_pkg::CH_N
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rd_data,
    input  logic               chan_wr,
    input  logic [N_CH-1:0]    chan_wdata,
    input  logic               det_pulse,
    output logic [N_CH-1:0]    chan_en_o,
    output logic               clk_src_o,
    output logic               path_sel_o,
    output logic               fwd_o,
    output logic               flag_o,
    output logic               err_o,
    output logic [RATIO_W-1:0] ratio_o
);

    ctrl_t ctrl_q;
    cmd_t  cmd;
    path_e path_q;
    logic  all_on;
    logic  sw_ok;

    vad_ctrl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q),
        .cmd     (cmd),
        .rd_data (rd_data),
        .ratio   (ratio_o)
    );

    vad_chan_en #(.N(N_CH)) u_chan (
        .clk       (clk),
        .rst       (rst),
        .en_rise   (cmd.en_rise),
        .ret_force (sw_ok),
        .ch_wr     (chan_wr),
        .ch_wdata  (chan_wdata),
        .chan_q    (chan_en_o),
        .all_on    (all_on)
    );

    vad_path_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .en        (ctrl_q.en),
        .cmd       (cmd),
        .det_pulse (det_pulse),
        .all_on    (all_on),
        .path_q    (path_q),
        .flag_q    (flag_o),
        .fwd_q     (fwd_o),
        .err_q     (err_o),
        .sw_ok     (sw_ok)
    );

    assign path_sel_o = (path_q == PATH_MIC);
    assign clk_src_o  = ctrl_q.en;

    a_r5_clk_src: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> clk_src_o == $past(wr_data[EN_BIT]));

    a_r8_mic_needs_enable: assert property (@(posedge clk) disable iff (rst)
        path_sel_o |-> clk_src_o);

endmodule

// File: tb/tb_vad_path_ctrl.sv
module tb_vad_path_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        chan_wr;
    logic [3:0]  chan_wdata;
    logic        det_pulse;
    logic [3:0]  chan_en_o;
    logic        clk_src_o, path_sel_o, fwd_o, flag_o, err_o;
    logic [6:0]  ratio_o;

    always #10 clk = ~clk;   // 50 MHz

    vad_path_ctrl dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .chan_wr(chan_wr), .chan_wdata(chan_wdata), .det_pulse(det_pulse),
        .chan_en_o(chan_en_o), .clk_src_o(clk_src_o), .path_sel_o(path_sel_o),
        .fwd_o(fwd_o), .flag_o(flag_o), .err_o(err_o), .ratio_o(ratio_o)
    );

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // reference model state
    logic       m_en, m_clr, m_sw, m_doff;
    logic [3:0] m_osr;
    logic [3:0] m_chan;
    logic       m_path, m_flag, m_fwd, m_err;

    function automatic logic [6:0] exp_ratio(input logic [3:0] c);
        return (c == 4'd0) ? 7'd48 : 7'd64;
    endfunction

    function automatic logic [31:0] exp_rd();
        logic [31:0] v;
        v = 32'h0000_0008;
        v[31] = m_en; v[30] = m_clr; v[29] = m_sw; v[28] = m_doff;
        v[11:8] = m_osr;
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk("R2 readback", rd_data, exp_rd());
        chk("R3 ratio", {25'd0, ratio_o}, {25'd0, exp_ratio(m_osr)});
        chk("R4 channels", {28'd0, chan_en_o}, {28'd0, m_chan});
        chk("R5 clock source", {31'd0, clk_src_o}, {31'd0, m_en});
        chk("R7 flag", {31'd0, flag_o}, {31'd0, m_flag});
        chk("R8 path", {31'd0, path_sel_o}, {31'd0, m_path});
        chk("R9 forward", {31'd0, fwd_o}, {31'd0, m_fwd});
        chk("R11 error", {31'd0, err_o}, {31'd0, m_err});
    endtask

    task automatic model_reset();
        m_en = 0; m_clr = 0; m_sw = 0; m_doff = 0; m_osr = 0;
        m_chan = 0; m_path = 0; m_flag = 0; m_fwd = 0; m_err = 0;
    endtask

    // model update for one edge, from the requirements
    task automatic model_step(input logic w, input logic [31:0] d, input logic det,
                              input logic cw, input logic [3:0] cd);
        logic dis, rise, acc, ok, bad;
        dis  = w && !d[31];
        rise = w && d[31] && !m_en;
        acc  = det && m_en && !m_path;
        ok   = w && d[29] && m_path && m_en && !m_flag && (m_chan == 4'hF);
        bad  = w && d[29] && m_path && !ok;
        if (acc) m_flag = 1; else if (w && d[30]) m_flag = 0;
        if (dis) m_path = 0; else if (acc) m_path = 1; else if (ok) m_path = 0;
        if (dis) m_fwd = 0; else if (acc) m_fwd = 1; else if ((w && d[28]) || ok) m_fwd = 0;
        if (bad) m_err = 1; else if (ok) m_err = 0;
        if (rise || ok) m_chan = 4'b0001; else if (cw) m_chan = cd;
        if (w) begin
            m_en = d[31]; m_clr = d[30]; m_sw = d[29]; m_doff = d[28]; m_osr = d[11:8];
        end
    endtask

    // called at a negedge; returns at the next negedge with outputs checked
    task automatic step(input logic w, input logic [31:0] d, input logic det,
                        input logic cw, input logic [3:0] cd);
        wr_en = w; wr_data = d; det_pulse = det; chan_wr = cw; chan_wdata = cd;
        @(posedge clk);
        model_step(w, d, det, cw, cd);
        @(negedge clk);
        wr_en = 0; det_pulse = 0; chan_wr = 0;
        check_all();
    endtask

    task automatic idle();
        step(1'b0, 32'h0, 1'b0, 1'b0, 4'h0);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_fail++;
                $display("FAIL watchdog: actual running expected finished");
                $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1; wr_en = 0; wr_data = 0; det_pulse = 0; chan_wr = 0; chan_wdata = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        chk("R1 reset readback", rd_data, 32'h0000_0008);
        chk("R1 reset outputs", {26'd0, chan_en_o, path_sel_o, fwd_o},  32'd0);
        check_all();

        // R6: pulse while disabled ignored
        step(1'b0, 0, 1'b1, 1'b0, 0);
        chk("R6 pulse ignored when disabled", {31'd0, flag_o}, 32'd0);
        // R2: reserved bits read zero, code 2 -> 64 (R3)
        step(1'b0, 0, 0, 0, 0);
        step(1'b1, 32'h0FFF_F2F7, 1'b0, 1'b0, 0);
        chk("R2 reserved bits zero", rd_data, 32'h0000_0208);
        chk("R3 unlisted code", {25'd0, ratio_o}, 32'd64);
        // R4: enable rise beats channel write
        step(1'b1, 32'h8000_0000, 1'b0, 1'b1, 4'hE);
        chk("R4 forced on enable", {28'd0, chan_en_o}, 32'd1);
        chk("R3 code 0", {25'd0, ratio_o}, 32'd48);
        step(1'b1, 32'h8000_0100, 1'b0, 1'b0, 0);
        chk("R3 code 1", {25'd0, ratio_o}, 32'd64);
        // R7 collision: clear write together with detection -> flag set, R8 path
        step(1'b1, 32'hC000_0100, 1'b1, 1'b0, 0);
        chk("R7 detection beats clear", {31'd0, flag_o}, 32'd1);
        chk("R8 path to microphone", {31'd0, path_sel_o}, 32'd1);
        chk("R9 forward on", {31'd0, fwd_o}, 32'd1);
        // R6: pulse while on microphone path ignored (after clearing)
        step(1'b1, 32'hC000_0100, 1'b0, 1'b1, 4'hF);
        step(1'b1, 32'h8000_0100, 1'b1, 1'b0, 0);
        chk("R6 pulse ignored on mic path", {31'd0, flag_o}, 32'd0);
        // R11: clear and switch in one write -> rejected since flag judged before
        step(1'b1, 32'h8000_0100, 0, 0, 0);
        m_flag = m_flag; // no-op
        // set flag again is impossible on mic path; reject via channels low
        step(1'b0, 0, 0, 1'b1, 4'h7);
        step(1'b1, 32'hE000_0100, 1'b0, 1'b0, 0);
        chk("R11 rejected switch error", {31'd0, err_o}, 32'd1);
        chk("R11 path unchanged", {31'd0, path_sel_o}, 32'd1);
        // R10: accepted switch
        step(1'b0, 0, 0, 1'b1, 4'hF);
        step(1'b1, 32'hA000_0100, 1'b0, 1'b0, 0);
        chk("R10 switch accepted", {31'd0, path_sel_o}, 32'd0);
        chk("R10 channels forced", {28'd0, chan_en_o}, 32'd1);
        chk("R10 forward stopped", {31'd0, fwd_o}, 32'd0);
        // R9 collision: data-off never reaches detection in same path; doff + detection
        step(1'b1, 32'h9000_0100, 1'b1, 1'b0, 0);
        chk("R9 detection beats data-off", {31'd0, fwd_o}, 32'd1);
        // R7 clear-with-switch in one write while flag set -> rejected
        step(1'b0, 0, 0, 1'b1, 4'hF);
        step(1'b1, 32'hE000_0100, 1'b0, 1'b0, 0);
        chk("R7 clear took effect", {31'd0, flag_o}, 32'd0);
        chk("R11 switch with clear rejected", {31'd0, err_o}, 32'd1);
        // R9 data-off alone
        step(1'b1, 32'h9000_0100, 1'b0, 1'b0, 0);
        chk("R9 data-off clears forward", {31'd0, fwd_o}, 32'd0);
        // R12 disable returns path
        step(1'b1, 32'h8000_0100, 1'b1, 1'b0, 0);
        step(1'b1, 32'h8000_0100, 1'b0, 1'b0, 0);
        step(1'b1, 32'h0000_0000, 1'b0, 1'b0, 0);
        chk("R12 disable to detection", {31'd0, path_sel_o}, 32'd0);
        chk("R5 clock source off", {31'd0, clk_src_o}, 32'd0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic        w, det, cw;
            logic [31:0] d;
            logic [3:0]  cd;
            w   = ($urandom_range(0, 3) == 0);
            d   = $urandom();
            d[31] = ($urandom_range(0, 9) != 0);
            d[30] = ($urandom_range(0, 3) == 0);
            d[29] = ($urandom_range(0, 3) == 0);
            d[28] = ($urandom_range(0, 4) == 0);
            det = ($urandom_range(0, 7) == 0);
            cw  = ($urandom_range(0, 7) == 0);
            cd  = ($urandom_range(0, 3) != 0) ? 4'hF : 4'($urandom());
            step(w, d, det, cw, cd);
        end
        idle();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        done = 1'b1;
        $finish;
    end

endmodule